// File: doc/BRIEF.md
# Virtual Screen Geometry and Pan Address Unit

This block holds the geometry of a virtual framebuffer that is larger than the visible picture, and the start address used to pan across it in a linear display mode. Software writes a virtual width. The block turns that width into bytes per scanline for the current colour depth. It then divides the video memory size by that value to get the number of scanlines the memory can hold. A width is kept only if it is at least the visible width and the resulting height is at least the visible height. Otherwise all geometry stays as it was.

Software also writes a horizontal and a vertical pan offset. After each offset write the block forms the byte address of the top-left visible pixel: the scanline pitch times the row offset, plus the column offset converted to bytes. It presents this address in 32-bit word units. The division is iterative. While it runs, `ready_o` is low and all writes are dropped.

Top module: `vscreen_geom`

## Requirements
- R1: After reset, line offset, virtual width, virtual height and start address are all zero, and `ready_o` is high.
- R2: At a depth of 4 bits per pixel, a width write produces a line offset of width >> 1 bytes.
- R3: At any other depth, a width write produces a line offset of width × ((depth + 7) >> 3) bytes.
- R4: The virtual height is VRAM_BYTES / line offset, rounded down. If the result exceeds 65535 it is clamped to 65535.
- R5: A width write whose value is below `xres_i` is rejected. Geometry is unchanged and `ready_o` stays high.
- R6: A width write whose derived height is below `yres_i` is rejected after the division, with geometry unchanged.
- R7: A width write that would give a line offset of zero is rejected at once, with geometry unchanged.
- R8: Virtual width, virtual height and line offset change only together, in the cycle after a division completes.
- R9: Selector code 1 stores the column offset and code 2 stores the row offset; code 0 is a width write and code 3 does nothing. In the cycle after an offset write, `start_addr_o` equals (line offset × row offset + column offset in bytes) >> 2. The bytes use the R2/R3 rule at the current depth.
- R10: While `ready_o` is low, writes of every kind are ignored.
- R11: An accepted width write holds `ready_o` low for the duration of the division, and `ready_o` returns high by itself afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Target: 0 width, 1 column offset, 2 row offset, 3 none |
| wr_data_i | input | DIM_W | Write value |
| xres_i | input | DIM_W | Visible width in pixels |
| yres_i | input | DIM_W | Visible height in lines |
| bpp_i | input | 6 | Colour depth in bits per pixel |
| ready_o | output | 1 | High when a write is accepted |
| line_ofs_o | output | ADDR_W | Bytes per scanline |
| virt_w_o | output | DIM_W | Virtual width in pixels |
| virt_h_o | output | DIM_W | Virtual height in lines |
| start_addr_o | output | ADDR_W | Display start in 32-bit words |

## Verification
The hardest case to reach is a write that arrives while the division is running. The block drops such writes, so at the ports they look like they never happened. The stimulus keeps the strobe high across the cycle after an accepted width write, with an offset value that would clearly move the start address. It then checks that the start address is unchanged once ready returns, and that the pending width still commits. A width of 16 at 8 bits per pixel makes the quotient overflow 16 bits and so exercises the height clamp. A 32-bit-per-pixel width of 4096 gives a height too small for the visible lines and so exercises the late rejection.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  typedef enum logic [1:0] {
    SEL_VWIDTH = 2'd0,
    SEL_XOFS   = 2'd1,
    SEL_YOFS   = 2'd2,
    SEL_NONE   = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/vsg_pix_bytes.sv
module vsg_pix_bytes #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned OUT_W = 32
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [5:0]       bpp_i,
  output logic [OUT_W-1:0] bytes_o
);
  logic [6:0] bpp_rnd;
  logic [3:0] per_pix;

  assign bpp_rnd = 7'(bpp_i) + 7'd7;
  assign per_pix = bpp_rnd[6:3];
  // 4 bpp packs two pixels per byte
  assign bytes_o = (bpp_i == 6'd4) ? OUT_W'(count_i >> 1)
                                   : OUT_W'(count_i) * OUT_W'(per_pix);
endmodule

// File: rtl/vsg_div.sv
module vsg_div #(
  parameter int unsigned NUM_W     = 23,
  parameter int unsigned DEN_W     = 32,
  parameter int unsigned NUMERATOR = 4194304
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] den_q, rem_q;
  logic [NUM_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [DEN_W:0]   rem_sh;
  logic             fits;

  assign rem_sh = {rem_q, quo_q[NUM_W-1]};
  assign fits   = rem_sh >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      den_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        den_q  <= den_i;
        rem_q  <= '0;
        quo_q  <= NUM_W'(NUMERATOR);
        cnt_q  <= CNT_W'(NUM_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= fits ? DEN_W'(rem_sh - {1'b0, den_q}) : rem_sh[DEN_W-1:0];
        quo_q <= {quo_q[NUM_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = quo_q;

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_no_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);
endmodule

// File: rtl/vscreen_geom.sv
module vscreen_geom
  import vsg_pkg::*;
#(
  parameter int unsigned DIM_W      = 16,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned VRAM_BYTES = 4194304
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DIM_W-1:0]  wr_data_i,
  input  logic [DIM_W-1:0]  xres_i,
  input  logic [DIM_W-1:0]  yres_i,
  input  logic [5:0]        bpp_i,
  output logic              ready_o,
  output logic [ADDR_W-1:0] line_ofs_o,
  output logic [DIM_W-1:0]  virt_w_o,
  output logic [DIM_W-1:0]  virt_h_o,
  output logic [ADDR_W-1:0] start_addr_o
);
  localparam int unsigned NUM_W = $clog2(VRAM_BYTES + 1);
  localparam int unsigned Q_W   = (NUM_W > DIM_W) ? NUM_W : DIM_W;
  localparam logic [Q_W-1:0] H_MAX = Q_W'({DIM_W{1'b1}});

  logic [DIM_W-1:0]  virt_w_q, virt_h_q, x_ofs_q, y_ofs_q, pend_w_q;
  logic [ADDR_W-1:0] lofs_q, pend_lofs_q, start_q;
  logic [ADDR_W-1:0] lofs_new, x_bytes, start_sum;
  logic [DIM_W-1:0]  x_next, y_next;
  logic [NUM_W-1:0]  quo;
  logic [Q_W-1:0]    quo_x;
  logic              div_busy, div_done, div_start;
  logic              accept, vw_wr, ofs_wr, narrow, zero_lofs;

  assign ready_o   = !(div_busy || div_done);
  assign accept    = wr_en_i && ready_o;
  assign vw_wr     = accept && (wr_sel_i == SEL_VWIDTH);
  assign ofs_wr    = accept && ((wr_sel_i == SEL_XOFS) || (wr_sel_i == SEL_YOFS));
  assign narrow    = wr_data_i < xres_i;
  assign zero_lofs = lofs_new == '0;
  assign div_start = vw_wr && !narrow && !zero_lofs;

  vsg_pix_bytes #(.CNT_W(DIM_W), .OUT_W(ADDR_W)) i_line_bytes (
    .count_i(wr_data_i), .bpp_i(bpp_i), .bytes_o(lofs_new));

  vsg_div #(.NUM_W(NUM_W), .DEN_W(ADDR_W), .NUMERATOR(VRAM_BYTES)) i_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_start), .den_i(lofs_new),
    .busy_o(div_busy), .done_o(div_done), .quo_o(quo));

  assign quo_x  = Q_W'(quo);
  assign x_next = (accept && wr_sel_i == SEL_XOFS) ? wr_data_i : x_ofs_q;
  assign y_next = (accept && wr_sel_i == SEL_YOFS) ? wr_data_i : y_ofs_q;

  vsg_pix_bytes #(.CNT_W(DIM_W), .OUT_W(ADDR_W)) i_pan_bytes (
    .count_i(x_next), .bpp_i(bpp_i), .bytes_o(x_bytes));

  assign start_sum = lofs_q * ADDR_W'(y_next) + x_bytes;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      virt_w_q    <= '0;
      virt_h_q    <= '0;
      lofs_q      <= '0;
      pend_w_q    <= '0;
      pend_lofs_q <= '0;
      x_ofs_q     <= '0;
      y_ofs_q     <= '0;
      start_q     <= '0;
    end else begin
      if (div_start) begin
        pend_w_q    <= wr_data_i;
        pend_lofs_q <= lofs_new;
      end
      if (div_done && (quo_x >= Q_W'(yres_i))) begin
        virt_w_q <= pend_w_q;
        lofs_q   <= pend_lofs_q;
        virt_h_q <= (quo_x > H_MAX) ? {DIM_W{1'b1}} : DIM_W'(quo_x);
      end
      if (ofs_wr) begin
        x_ofs_q <= x_next;
        y_ofs_q <= y_next;
        start_q <= start_sum >> 2;
      end
    end
  end

  assign line_ofs_o   = lofs_q;
  assign virt_w_o     = virt_w_q;
  assign virt_h_o     = virt_h_q;
  assign start_addr_o = start_q;

  p_geom_sync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(virt_w_o) || !$stable(virt_h_o) || !$stable(line_ofs_o)) |-> $past(div_done));
  p_narrow_reject_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ready_o && wr_sel_i == SEL_VWIDTH && wr_data_i < xres_i)
      |=> (ready_o && $stable(virt_w_o) && $stable(line_ofs_o)));
  p_zero_reject_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ready_o && wr_sel_i == SEL_VWIDTH && bpp_i == 6'd4 && wr_data_i < DIM_W'(2))
      |=> ready_o);
  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(start_addr_o));
endmodule

// File: tb/test_vscreen_geom.sv
module test_vscreen_geom;
  localparam int unsigned VRAM = 4194304;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [15:0] wr_data = '0;
  logic [15:0] xres = '0, yres = '0;
  logic [5:0]  bpp = 6'd8;
  logic        ready;
  logic [31:0] line_ofs, start_addr;
  logic [15:0] virt_w, virt_h;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  vscreen_geom i_vscreen_geom (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .xres_i(xres), .yres_i(yres), .bpp_i(bpp),
    .ready_o(ready), .line_ofs_o(line_ofs), .virt_w_o(virt_w),
    .virt_h_o(virt_h), .start_addr_o(start_addr));

  task automatic check(input string req, input string what, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic longint pix_bytes(input longint n, input int d);
    if (d == 4) return n >> 1;
    return n * ((d + 7) >> 3);
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
    while (!ready) @(negedge clk);
  endtask

  task automatic geom_ok(input string req, input int d, input int w);
    longint lo, h;
    bpp = 6'(d);
    wr(2'd0, 16'(w));
    lo = pix_bytes(w, d);
    h = VRAM / lo;
    if (h > 65535) h = 65535;
    check(req, "line_ofs", line_ofs, lo);
    check(req, "virt_w", virt_w, w);
    check(req, "virt_h", virt_h, h);
  endtask

  task automatic t_reset;
    check("R1", "line_ofs", line_ofs, 0);
    check("R1", "virt_w", virt_w, 0);
    check("R1", "virt_h", virt_h, 0);
    check("R1", "start", start_addr, 0);
    check("R1", "ready", ready, 1);
  endtask

  task automatic t_depths;
    xres = 16'd640; yres = 16'd480;
    geom_ok("R2", 4, 800);
    geom_ok("R3", 8, 1024);
    geom_ok("R3", 24, 1000);
    geom_ok("R3", 15, 800);
    geom_ok("R8", 32, 700);
  endtask

  task automatic t_saturate;
    xres = 16'd8; yres = 16'd8;
    geom_ok("R4", 8, 16);
  endtask

  task automatic t_rejects;
    longint w0, h0, l0;
    xres = 16'd640; yres = 16'd480;
    geom_ok("R3", 8, 1024);
    w0 = virt_w; h0 = virt_h; l0 = line_offs_dummy(line_ofs);
    bpp = 6'd8;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'd600;
    @(negedge clk);
    wr_en = 1'b0;
    check("R5", "ready after narrow", ready, 1);
    check("R5", "virt_w", virt_w, w0);
    check("R5", "line_ofs", line_ofs, l0);
    bpp = 6'd32;
    wr(2'd0, 16'd4096);
    check("R6", "virt_w", virt_w, w0);
    check("R6", "virt_h", virt_h, h0);
    check("R6", "line_ofs", line_ofs, l0);
    xres = 16'd0; bpp = 6'd4;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'd1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7", "ready after zero", ready, 1);
    check("R7", "virt_w", virt_w, w0);
    check("R7", "line_ofs", line_ofs, l0);
  endtask

  function automatic longint line_offs_dummy(input longint v);
    return v;
  endfunction

  task automatic t_pan;
    xres = 16'd640; yres = 16'd480;
    geom_ok("R3", 8, 1024);
    bpp = 6'd8;
    wr(2'd1, 16'd10);
    check("R9", "start x only", start_addr, (0 * 1024 + 10) >> 2);
    wr(2'd2, 16'd3);
    check("R9", "start 8bpp", start_addr, (3 * 1024 + 10) >> 2);
    bpp = 6'd4;
    wr(2'd1, 16'd10);
    check("R9", "start 4bpp", start_addr, (3 * 1024 + 5) >> 2);
    bpp = 6'd32;
    wr(2'd2, 16'd3);
    check("R9", "start 32bpp", start_addr, (3 * 1024 + 40) >> 2);
    wr(2'd3, 16'd77);
    check("R9", "sel none", start_addr, (3 * 1024 + 40) >> 2);
  endtask

  task automatic t_busy;
    longint s0;
    s0 = start_addr;
    bpp = 6'd8; xres = 16'd640; yres = 16'd480;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'd2048;
    @(negedge clk);
    check("R11", "ready low while dividing", ready, 0);
    wr_sel = 2'd2; wr_data = 16'd100;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
    while (!ready) @(negedge clk);
    check("R10", "start held", start_addr, s0);
    check("R11", "virt_w committed", virt_w, 2048);
    check("R11", "line_ofs committed", line_ofs, 2048);
    wr(2'd2, 16'd1);
    check("R9", "start after busy", start_addr, (2048 + 10) >> 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_depths();
    t_saturate();
    t_rejects();
    t_pan();
    t_busy();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule